// File: doc/BRIEF.md
# Slave Word-Clock Output Sequencer

This block sits on the receiving end of a serial display link. It takes frames that the deserializer has already decoded and turns each one into a bus cycle on the display side. A write frame puts a data word and a control word on the pins. After a programmed lead time it pulls the matching word clock low for a programmed width, then releases it. A read frame drives control and sets the direction line high. It also tri-states the data bus by dropping its output enable and then pulses the word clock. On the rising edge that ends the pulse it captures what the display drives, hands those 18 bits to the return serializer, and takes the bus back.

A serial-interface frame reuses the same pins. The serial clock comes out on data bit 6 and on control bit 5, the serial data bit on data bit 7 and on control bit 4, and the chip-select level on word clock 0. Every lead and pulse width is a cycle count for a fast internal clock of about 275 MHz. The slew select picks the short end of each width range (fast edges) or the long end (slow edges). A frame that arrives while a sequence runs is dropped, and `busy` shows when a sequence is in progress.

Top module: `slave_wclk_seq`

## Requirements
- R1: After reset both word clocks are high, `dp_out` and `ctl_out` are zero, `dp_oe` is 1, `rw_out`, `busy` and `ret_valid` are 0.
- R2: Frame kind 0 (channel-0 write) drives `dp_out`=frame data, `ctl_out`=frame control, `rw_out`=0, `dp_oe`=1 from the cycle after acceptance. `wck0` falls 14 cycles later and stays low 14 cycles with `slew_fast`=1, or 15 cycles with `slew_fast`=0.
- R3: Frame kind 1 (channel-1 write) behaves like R2 on `wck1`, with a 5-cycle lead and a low width of 5 (fast) or 6 (slow) cycles.
- R4: Frame kinds 2 and 3 (read on channel 0 or 1) drive `ctl_out`=frame control, `rw_out`=1 and `dp_oe`=0 from the cycle after acceptance. `wck0` (kind 2) or `wck1` (kind 3) falls 55 cycles later and stays low 55 (fast) or 60 (slow) cycles.
- R5: At the edge that ends a read pulse, `disp_din` is captured into `ret_data`, `ret_valid` is 1 for exactly that one cycle, and `dp_oe` returns to 1. Values on `disp_din` before that edge are not captured.
- R6: Frame kind 4 (serial) sets `wck0` to frame data bit 0 (chip select). It puts frame control bit 4 on `dp_out[7]` and `ctl_out[4]`, puts the other control bits on `ctl_out[3:0]`, holds the serial clock (`dp_out[6]`, `ctl_out[5]`) high, keeps the other data bits, and keeps `rw_out`=0. The serial clock falls 11 cycles later and stays low 11 (fast) or 15 (slow) cycles. `wck0` keeps the chip-select level afterwards.
- R7: `busy` is 1 from the cycle after acceptance through the last low cycle. A frame offered while `busy` is 1 is ignored and leaves no trace on the outputs.
- R8: Frame kinds 5, 6 and 7 are ignored: no sequence starts and no output changes.
- R9: A word clock is only low while `busy` is 1, and a sequence never starts with its clock already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (about 275 MHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_kind | input | 3 | 0 wr ch0, 1 wr ch1, 2 rd ch0, 3 rd ch1, 4 serial, 5-7 illegal |
| frm_data | input | 18 | Frame data word (bit 0 = chip select for serial frames) |
| frm_ctrl | input | 6 | Frame control word |
| slew_fast | input | 1 | 1 = fast edges, short pulse widths; 0 = slow edges, long widths |
| disp_din | input | 18 | Data driven by the display during a read |
| dp_out | output | 18 | Display data bus output value |
| dp_oe | output | 1 | Data bus output enable (0 during a read) |
| ctl_out | output | 6 | Display control outputs |
| rw_out | output | 1 | Direction line, 1 = read |
| wck0 | output | 1 | Channel-0 word clock / serial chip select |
| wck1 | output | 1 | Channel-1 word clock |
| busy | output | 1 | Sequence in progress |
| ret_valid | output | 1 | One-cycle strobe with captured read data |
| ret_data | output | 18 | Captured read data for the return serializer |

## Verification
The bound checker watches several rules on every cycle. Channel 1's clock never sits low outside a sequence. The bus is released only with the direction line high. Return data and bus recovery line up with a rising word clock. Each low pulse stays within the longest allowed width. Exact lead and width counts for each kind and slew setting, the chip-select behaviour of serial frames, the capture of late display data, and the dropping of frames offered while busy or with illegal kinds depend on what was sent. Only the bench's scoreboard can show these, because it compares each observed pulse against an expectation built from the requirements.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    FK_WR0 = 3'd0,
    FK_WR1 = 3'd1,
    FK_RD0 = 3'd2,
    FK_RD1 = 3'd3,
    FK_SPI = 3'd4
  } fkind_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  function automatic logic kind_legal(input logic [2:0] k);
    return (k <= 3'd4);
  endfunction
endpackage

// File: rtl/sws_timer.sv
// Down counter shared by the lead and low phases.
module sws_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sws_seq.sv
// Phase controller: admission, lead phase, low phase.
module sws_seq import sws_pkg::*; #(
  parameter int CNT_W     = 8,
  parameter int LEAD_WR0  = 14,
  parameter int LOW_WR0_F = 14,
  parameter int LOW_WR0_S = 15,
  parameter int LEAD_WR1  = 5,
  parameter int LOW_WR1_F = 5,
  parameter int LOW_WR1_S = 6,
  parameter int LEAD_RD   = 55,
  parameter int LOW_RD_F  = 55,
  parameter int LOW_RD_S  = 60,
  parameter int LEAD_SPI  = 11,
  parameter int LOW_SPI_F = 11,
  parameter int LOW_SPI_S = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_valid,
  input  logic [2:0] frm_kind,
  input  logic       slew_fast,
  output logic       ev_start,
  output logic       ev_fall,
  output logic       ev_rise,
  output fkind_t     run_kind,
  output logic       busy
);
  phase_t ph_q, ph_d;
  fkind_t kind_q, kind_d;
  logic   slew_q, slew_d;
  logic   tm_load, tm_exp;
  logic [CNT_W-1:0] tm_val, lead_sel, low_sel;
  logic   accept;

  sws_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tm_load),
    .load_val (tm_val),
    .expired  (tm_exp)
  );

  // Lead depends on the incoming frame, width on the running one.
  always_comb begin
    case (frm_kind)
      3'd0:       lead_sel = CNT_W'(LEAD_WR0 - 1);
      3'd1:       lead_sel = CNT_W'(LEAD_WR1 - 1);
      3'd2, 3'd3: lead_sel = CNT_W'(LEAD_RD - 1);
      default:    lead_sel = CNT_W'(LEAD_SPI - 1);
    endcase
    case (kind_q)
      FK_WR0:         low_sel = slew_q ? CNT_W'(LOW_WR0_F - 1) : CNT_W'(LOW_WR0_S - 1);
      FK_WR1:         low_sel = slew_q ? CNT_W'(LOW_WR1_F - 1) : CNT_W'(LOW_WR1_S - 1);
      FK_RD0, FK_RD1: low_sel = slew_q ? CNT_W'(LOW_RD_F - 1)  : CNT_W'(LOW_RD_S - 1);
      default:        low_sel = slew_q ? CNT_W'(LOW_SPI_F - 1) : CNT_W'(LOW_SPI_S - 1);
    endcase
  end

  assign accept = (ph_q == PH_IDLE) && frm_valid && kind_legal(frm_kind);

  always_comb begin
    ph_d    = ph_q;
    kind_d  = kind_q;
    slew_d  = slew_q;
    tm_load = 1'b0;
    tm_val  = lead_sel;
    case (ph_q)
      PH_IDLE: if (accept) begin
        ph_d    = PH_LEAD;
        kind_d  = fkind_t'(frm_kind);
        slew_d  = slew_fast;
        tm_load = 1'b1;
        tm_val  = lead_sel;
      end
      PH_LEAD: if (tm_exp) begin
        ph_d    = PH_LOW;
        tm_load = 1'b1;
        tm_val  = low_sel;
      end
      PH_LOW: if (tm_exp) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      kind_q <= FK_WR0;
      slew_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        kind_q <= kind_d;
        slew_q <= slew_d;
      end
    end
  end

  assign ev_start = accept;
  assign ev_fall  = (ph_q == PH_LEAD) && tm_exp;
  assign ev_rise  = (ph_q == PH_LOW) && tm_exp;
  assign run_kind = kind_q;
  assign busy     = (ph_q != PH_IDLE);
endmodule

// File: rtl/sws_pins.sv
// Registered display-side pins, updated on sequence events.
module sws_pins import sws_pkg::*; #(
  parameter int DW = 18,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_fall,
  input  logic          ev_rise,
  input  logic [2:0]    start_kind,
  input  fkind_t        run_kind,
  input  logic [DW-1:0] frm_data,
  input  logic [CW-1:0] frm_ctrl,
  input  logic [DW-1:0] disp_din,
  output logic [DW-1:0] dp_out,
  output logic          dp_oe,
  output logic [CW-1:0] ctl_out,
  output logic          rw_out,
  output logic          wck0,
  output logic          wck1,
  output logic          ret_valid,
  output logic [DW-1:0] ret_data
);
  localparam int SCK_DP = 6;
  localparam int SDA_DP = 7;
  localparam int SCK_CT = 5;
  localparam int SDA_CT = 4;

  logic [DW-1:0] dp_q, dp_d, ret_q;
  logic [CW-1:0] ctl_q, ctl_d;
  logic oe_q, oe_d, rw_q, rw_d, w0_q, w0_d, w1_q, w1_d, rv_q, rv_d, cap_en;
  logic is_rd_run;

  assign is_rd_run = (run_kind == FK_RD0) || (run_kind == FK_RD1);

  always_comb begin
    dp_d   = dp_q;
    ctl_d  = ctl_q;
    oe_d   = oe_q;
    rw_d   = rw_q;
    w0_d   = w0_q;
    w1_d   = w1_q;
    rv_d   = 1'b0;
    cap_en = 1'b0;
    if (ev_start) begin
      ctl_d = frm_ctrl;
      w1_d  = 1'b1;
      case (start_kind)
        3'd0, 3'd1: begin
          dp_d = frm_data;
          rw_d = 1'b0;
          oe_d = 1'b1;
          w0_d = 1'b1;
        end
        3'd2, 3'd3: begin
          rw_d = 1'b1;
          oe_d = 1'b0;
          w0_d = 1'b1;
        end
        default: begin
          ctl_d[SCK_CT] = 1'b1;
          dp_d[SCK_DP]  = 1'b1;
          dp_d[SDA_DP]  = frm_ctrl[SDA_CT];
          rw_d          = 1'b0;
          oe_d          = 1'b1;
          w0_d          = frm_data[0];
        end
      endcase
    end
    if (ev_fall) begin
      case (run_kind)
        FK_WR0, FK_RD0: w0_d = 1'b0;
        FK_WR1, FK_RD1: w1_d = 1'b0;
        default: begin
          dp_d[SCK_DP]  = 1'b0;
          ctl_d[SCK_CT] = 1'b0;
        end
      endcase
    end
    if (ev_rise) begin
      case (run_kind)
        FK_WR0, FK_RD0: w0_d = 1'b1;
        FK_WR1, FK_RD1: w1_d = 1'b1;
        default: begin
          dp_d[SCK_DP]  = 1'b1;
          ctl_d[SCK_CT] = 1'b1;
        end
      endcase
      if (is_rd_run) begin
        cap_en = 1'b1;
        rv_d   = 1'b1;
        oe_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q  <= '0;
      ctl_q <= '0;
      oe_q  <= 1'b1;
      rw_q  <= 1'b0;
      w0_q  <= 1'b1;
      w1_q  <= 1'b1;
      rv_q  <= 1'b0;
      ret_q <= '0;
    end else begin
      dp_q  <= dp_d;
      ctl_q <= ctl_d;
      oe_q  <= oe_d;
      rw_q  <= rw_d;
      w0_q  <= w0_d;
      w1_q  <= w1_d;
      rv_q  <= rv_d;
      if (cap_en) ret_q <= disp_din;
    end
  end

  assign dp_out    = dp_q;
  assign ctl_out   = ctl_q;
  assign dp_oe     = oe_q;
  assign rw_out    = rw_q;
  assign wck0      = w0_q;
  assign wck1      = w1_q;
  assign ret_valid = rv_q;
  assign ret_data  = ret_q;
endmodule

// File: rtl/slave_wclk_seq.sv
module slave_wclk_seq import sws_pkg::*; #(
  parameter int DW        = 18,
  parameter int CW        = 6,
  parameter int CNT_W     = 8,
  parameter int LEAD_WR0  = 14,
  parameter int LOW_WR0_F = 14,
  parameter int LOW_WR0_S = 15,
  parameter int LEAD_WR1  = 5,
  parameter int LOW_WR1_F = 5,
  parameter int LOW_WR1_S = 6,
  parameter int LEAD_RD   = 55,
  parameter int LOW_RD_F  = 55,
  parameter int LOW_RD_S  = 60,
  parameter int LEAD_SPI  = 11,
  parameter int LOW_SPI_F = 11,
  parameter int LOW_SPI_S = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [2:0]    frm_kind,
  input  logic [DW-1:0] frm_data,
  input  logic [CW-1:0] frm_ctrl,
  input  logic          slew_fast,
  input  logic [DW-1:0] disp_din,
  output logic [DW-1:0] dp_out,
  output logic          dp_oe,
  output logic [CW-1:0] ctl_out,
  output logic          rw_out,
  output logic          wck0,
  output logic          wck1,
  output logic          busy,
  output logic          ret_valid,
  output logic [DW-1:0] ret_data
);
  logic [1:0] rs_q;
  logic       rst_sync_n;
  logic       ev_start, ev_fall, ev_rise;
  fkind_t     run_kind;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  sws_seq #(
    .CNT_W(CNT_W),
    .LEAD_WR0(LEAD_WR0), .LOW_WR0_F(LOW_WR0_F), .LOW_WR0_S(LOW_WR0_S),
    .LEAD_WR1(LEAD_WR1), .LOW_WR1_F(LOW_WR1_F), .LOW_WR1_S(LOW_WR1_S),
    .LEAD_RD(LEAD_RD),   .LOW_RD_F(LOW_RD_F),   .LOW_RD_S(LOW_RD_S),
    .LEAD_SPI(LEAD_SPI), .LOW_SPI_F(LOW_SPI_F), .LOW_SPI_S(LOW_SPI_S)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frm_valid (frm_valid),
    .frm_kind  (frm_kind),
    .slew_fast (slew_fast),
    .ev_start  (ev_start),
    .ev_fall   (ev_fall),
    .ev_rise   (ev_rise),
    .run_kind  (run_kind),
    .busy      (busy)
  );

  sws_pins #(.DW(DW), .CW(CW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_start   (ev_start),
    .ev_fall    (ev_fall),
    .ev_rise    (ev_rise),
    .start_kind (frm_kind),
    .run_kind   (run_kind),
    .frm_data   (frm_data),
    .frm_ctrl   (frm_ctrl),
    .disp_din   (disp_din),
    .dp_out     (dp_out),
    .dp_oe      (dp_oe),
    .ctl_out    (ctl_out),
    .rw_out     (rw_out),
    .wck0       (wck0),
    .wck1       (wck1),
    .ret_valid  (ret_valid),
    .ret_data   (ret_data)
  );
endmodule

// File: rtl/sws_wclk_chk.sv
module sws_wclk_chk #(
  parameter int MAX_LOW = 60
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic wck0,
  input logic wck1,
  input logic dp_oe,
  input logic rw_out,
  input logic ret_valid
);
  int unsigned low1_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low1_cnt <= 0;
    else if (!wck1) low1_cnt <= low1_cnt + 1;
    else            low1_cnt <= 0;
  end

  a_r9_wck1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wck1);

  a_r9_start_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wck1);

  a_r4_release_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_oe) |-> rw_out);

  a_r4_read_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rw_out) |-> !dp_oe);

  a_r5_return_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ($rose(wck0) || $rose(wck1)));

  a_r5_bus_back_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_oe) |-> ret_valid);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid);

  a_r3_wck1_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    low1_cnt <= MAX_LOW);
endmodule

bind slave_wclk_seq sws_wclk_chk #(.MAX_LOW(LOW_RD_S)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .wck0      (wck0),
  .wck1      (wck1),
  .dp_oe     (dp_oe),
  .rw_out    (rw_out),
  .ret_valid (ret_valid)
);

// File: tb/slave_wclk_seq_test.sv
module slave_wclk_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid;
  logic [2:0]  frm_kind;
  logic [17:0] frm_data;
  logic [5:0]  frm_ctrl;
  logic        slew_fast;
  logic [17:0] disp_din;
  logic [17:0] dp_out;
  logic        dp_oe;
  logic [5:0]  ctl_out;
  logic        rw_out;
  logic        wck0, wck1, busy, ret_valid;
  logic [17:0] ret_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slave_wclk_seq uut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_kind(frm_kind),
    .frm_data(frm_data), .frm_ctrl(frm_ctrl), .slew_fast(slew_fast),
    .disp_din(disp_din), .dp_out(dp_out), .dp_oe(dp_oe), .ctl_out(ctl_out),
    .rw_out(rw_out), .wck0(wck0), .wck1(wck1), .busy(busy),
    .ret_valid(ret_valid), .ret_data(ret_data)
  );

  typedef struct {
    int          sel;    // 0 wck0, 1 wck1, 2 serial clock
    logic [17:0] dp;
    bit          dp_chk;
    logic [5:0]  ctl;
    logic        rw;
    logic        oe;
    int          lead;
    int          low;
    bit          is_rd;
    logic [17:0] ret;
    logic        cs;
    string       req;
  } exp_t;

  exp_t q[$];
  logic [17:0] last_dp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: measures each pulse and compares with the queue head.
  int  bcnt = 0;
  int  lowc = 0;
  bit  seen = 0;
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      logic clkv;
      exp_t e;
      e = q[0];
      case (e.sel)
        0:       clkv = wck0;
        1:       clkv = wck1;
        default: clkv = dp_out[6];
      endcase
      if (busy && !seen) bcnt++;
      if (!seen && busy && !clkv) begin
        seen = 1;
        lowc = 1;
        chk(bcnt - 1 == e.lead, e.req, "lead cycles", bcnt - 1, e.lead);
        if (e.dp_chk) chk(dp_out == e.dp, e.req, "dp_out", dp_out, e.dp);
        chk(ctl_out == e.ctl, e.req, "ctl_out", ctl_out, e.ctl);
        chk(rw_out == e.rw, e.req, "rw_out", rw_out, e.rw);
        chk(dp_oe == e.oe, e.req, "dp_oe", dp_oe, e.oe);
        if (e.sel == 2) begin
          chk(wck0 == e.cs, "R6", "chip select on wck0", wck0, e.cs);
          chk(wck1 == 1'b1, "R6", "wck1 idle", wck1, 1);
        end
      end else if (seen && !clkv) begin
        lowc++;
      end else if (seen && clkv) begin
        chk(lowc == e.low, e.req, "low width", lowc, e.low);
        chk(busy == 1'b0, "R7", "busy after pulse", busy, 0);
        chk(dp_oe == 1'b1, e.req, "dp_oe after pulse", dp_oe, 1);
        chk(ret_valid == e.is_rd, "R5", "ret_valid at rise", ret_valid, e.is_rd);
        if (e.is_rd) chk(ret_data == e.ret, "R5", "ret_data", ret_data, e.ret);
        if (e.sel == 2) begin
          chk(ctl_out[5] == 1'b1, "R6", "sclk on ctl5 back high", ctl_out[5], 1);
          chk(wck0 == e.cs, "R6", "chip select kept", wck0, e.cs);
        end
        void'(q.pop_front());
        seen = 0;
        bcnt = 0;
      end
    end
  end

  // Driver: builds the expectation from the requirements and sends a frame.
  task automatic send(input logic [2:0] k, input logic [17:0] d, input logic [5:0] c,
                      input logic fast, input logic [17:0] din, input bit intrude);
    exp_t e;
    e.dp_chk = 1; e.is_rd = 0; e.ret = '0; e.cs = 1'b1;
    e.dp = d; e.ctl = c; e.rw = 1'b0; e.oe = 1'b1;
    case (k)
      3'd0: begin e.sel = 0; e.lead = 14; e.low = fast ? 14 : 15; e.req = "R2"; end
      3'd1: begin e.sel = 1; e.lead = 5;  e.low = fast ? 5 : 6;   e.req = "R3"; end
      3'd2, 3'd3: begin
        e.sel = (k == 3'd2) ? 0 : 1; e.lead = 55; e.low = fast ? 55 : 60;
        e.req = "R4"; e.rw = 1'b1; e.oe = 1'b0; e.dp_chk = 0; e.is_rd = 1; e.ret = din;
      end
      default: begin
        e.sel = 2; e.lead = 11; e.low = fast ? 11 : 15; e.req = "R6";
        e.dp = last_dp; e.dp[7] = c[4]; e.dp[6] = 1'b0;
        e.ctl = {1'b0, c[4:0]}; e.cs = d[0];
      end
    endcase
    q.push_back(e);
    @(negedge clk);
    frm_valid = 1'b1; frm_kind = k; frm_data = d; frm_ctrl = c; slew_fast = fast;
    if (e.is_rd) disp_din = ~din;
    @(negedge clk);
    frm_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (intrude) begin
      frm_valid = 1'b1; frm_kind = 3'd1; frm_data = ~d; frm_ctrl = ~c;
      @(negedge clk);
      frm_valid = 1'b0;
    end
    if (e.is_rd) disp_din = din;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    if (k <= 3'd1) last_dp = d;
    else if (k == 3'd4) begin last_dp[7] = c[4]; last_dp[6] = 1'b1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frm_valid = 1'b0; frm_kind = '0; frm_data = '0; frm_ctrl = '0;
    slew_fast = 1'b1; disp_din = '0; last_dp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(wck0 == 1'b1 && wck1 == 1'b1, "R1", "word clocks", {wck0, wck1}, 2'b11);
    chk(dp_out == '0, "R1", "dp_out", dp_out, 0);
    chk(ctl_out == '0, "R1", "ctl_out", ctl_out, 0);
    chk(dp_oe == 1'b1, "R1", "dp_oe", dp_oe, 1);
    chk(rw_out == 1'b0 && busy == 1'b0 && ret_valid == 1'b0, "R1", "rw/busy/ret_valid",
        {rw_out, busy, ret_valid}, 0);

    send(3'd0, 18'h2A5C3, 6'h15, 1'b1, '0, 0);   // R2 fast
    send(3'd0, 18'h15A3C, 6'h2A, 1'b0, '0, 0);   // R2 slow
    send(3'd1, 18'h3FFFF, 6'h3F, 1'b1, '0, 0);   // R3 fast
    send(3'd1, 18'h00001, 6'h01, 1'b0, '0, 0);   // R3 slow
    send(3'd2, 18'h0, 6'h0C, 1'b1, 18'h1B2C3, 0); // R4 R5 ch0 fast
    send(3'd3, 18'h0, 6'h33, 1'b0, 18'h2D4E5, 0); // R4 R5 ch1 slow
    send(3'd4, 18'h0, 6'h10, 1'b1, '0, 0);       // R6 cs low, sdat 1
    send(3'd4, 18'h0, 6'h05, 1'b0, '0, 0);       // R6 cs low, sdat 0
    send(3'd4, 18'h1, 6'h1F, 1'b1, '0, 0);       // R6 cs high
    send(3'd0, 18'h0F0F0, 6'h09, 1'b1, '0, 0);   // R2 after serial

    // R7: frame offered while busy is dropped
    send(3'd0, 18'h12345, 6'h21, 1'b1, '0, 1);
    chk(busy == 1'b0, "R7", "no second sequence", busy, 0);
    chk(dp_out == 18'h12345, "R7", "dp_out untouched by dropped frame", dp_out, 18'h12345);
    chk(wck1 == 1'b1, "R7", "wck1 not pulsed", wck1, 1);

    // R8: illegal kinds ignored
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_kind = 3'(k); frm_data = 18'h3C3C3; frm_ctrl = 6'h3C;
      @(negedge clk);
      frm_valid = 1'b0;
      chk(busy == 1'b0, "R8", "busy after illegal kind", busy, 0);
      chk(dp_out == 18'h12345 && ctl_out == 6'h21, "R8", "outputs unchanged",
          {ctl_out, dp_out}, {6'h21, 18'h12345});
    end
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && wck0 && wck1, "R8", "still idle", {busy, wck0, wck1}, 3'b011);
    chk(q.size() == 0, "R7", "all expected pulses observed", q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule